// File: doc/BRIEF.md
# Masked Address Match Filter

This block tells the receive path whether an incoming frame's 48-bit network identifier belongs to this station, so that the path can decide whether to acknowledge it. Software programs the station's own MAC address and a per-bit mask through a small register write port. Each time the frame parser presents an identifier with a strobe, the block compares only the bit positions where the mask holds a one. One clock later it returns a registered accept flag together with a result-valid pulse.

With an all-ones mask the filter locks onto a single network. Clearing mask bits where the served identifiers differ from the station address lets one filter answer for several virtual networks. The cost is that some unrelated identifiers that agree on every compared bit are also accepted. This is normal behaviour and is not reported as an error. The upper half of the second address register carries a 16-bit control field that neighbouring logic decodes. Byte-enabled writes let software update the address bytes without touching that field.

Top module: `addr_match_filter`

## Requirements
- R1: A strobed identifier F is accepted exactly when (F & MASK) == (MASK & MAC); in every other case it is rejected.
- R2: With an all-ones mask, only an identifier equal to the station address in all 48 bits is accepted. A single differing bit, including bit 0 or bit 47, causes a reject.
- R3: Mask bits that are zero are ignored, so an all-zero mask accepts every identifier.
- R4: Identifiers outside the served set are accepted when they agree on all masked bits. For example, with MASK=0x2 and MAC=0x1, identifier 0xD is accepted, 0x6 is rejected, and no error indication exists.
- R5: Octet n of the address sits at bits [8n+7:8n] of both MAC and frm_addr. Register 0 holds octets 0 to 3, with octet 0 in bits [7:0]. Register 1 holds octets 4 and 5 in bits [15:0].
- R6: Bits [31:16] of register 1 form a control field, which is driven on sta_ctrl. Each set bit of wr_be[i] writes byte i only. A write to register 1 with wr_be[3:2]=00 leaves sta_ctrl unchanged.
- R7: The mask is held in register 2 (mask bits [31:0]) and bits [15:0] of register 3 (mask bits [47:32]), with the same octet order as the address. Bits [31:16] of a write to register 3 have no effect.
- R8: match_vld is high for exactly the cycle after each cycle in which addr_vld is high, and is low otherwise. match_o is low whenever match_vld is low.
- R9: After reset the mask is all ones, the address and sta_ctrl are zero, and match_vld and match_o are low.
- R10: A register write is used by compares strobed on the following cycles. A compare strobed in the same cycle as a write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 addr low, 1 addr high/control, 2 mask low, 3 mask high |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for wr_data |
| addr_vld | input | 1 | Identifier strobe |
| frm_addr | input | 48 | Identifier from the received frame |
| match_vld | output | 1 | Result valid, one cycle after addr_vld |
| match_o | output | 1 | Accept flag, qualified by match_vld |
| sta_ctrl | output | 16 | Control field from bits [31:16] of register 1 |

## Verification
Several properties are checked on every cycle: the one-cycle timing of the result pulse and its qualification of the accept flag, exact matching under an all-ones mask, unconditional accept under an all-zero mask, and the control field staying put across address-only writes. The bench scenarios cover the rest. These include the octet ordering of both register pairs, the ignored upper half of the high mask register, and the reset contents. They also cover the deliberate false accept of an unserved identifier and the old-value compare when a write and a strobe arrive in the same cycle.

// File: rtl/amf_pkg.sv
package amf_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 48;
  localparam int BYTE_W  = 8;
  localparam int HI_W    = ADDR_W - REG_W;
  localparam int CTRL_W  = REG_W - HI_W;
  localparam int REG_NB  = REG_W / BYTE_W;
  localparam int HI_NB   = HI_W / BYTE_W;

  typedef enum logic [1:0] {
    RG_STA_LO = 2'd0,
    RG_STA_HI = 2'd1,
    RG_MSK_LO = 2'd2,
    RG_MSK_HI = 2'd3
  } amf_reg_e;
endpackage

// File: rtl/amf_regfile.sv
module amf_regfile
  import amf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [REG_NB-1:0] wr_be,
  output logic [ADDR_W-1:0] sta_mac,
  output logic [ADDR_W-1:0] msk,
  output logic [CTRL_W-1:0] sta_ctrl
);
  logic [REG_W-1:0] sta_lo_q, sta_lo_d;
  logic [REG_W-1:0] sta_hi_q, sta_hi_d;
  logic [REG_W-1:0] msk_lo_q, msk_lo_d;
  logic [HI_W-1:0]  msk_hi_q, msk_hi_d;

  // next-state: byte-merged write data into the selected register
  always_comb begin
    sta_lo_d = sta_lo_q;
    sta_hi_d = sta_hi_q;
    msk_lo_d = msk_lo_q;
    msk_hi_d = msk_hi_q;
    case (amf_reg_e'(wr_addr))
      RG_STA_LO: for (int b = 0; b < REG_NB; b++)
                   if (wr_be[b]) sta_lo_d[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
      RG_STA_HI: for (int b = 0; b < REG_NB; b++)
                   if (wr_be[b]) sta_hi_d[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
      RG_MSK_LO: for (int b = 0; b < REG_NB; b++)
                   if (wr_be[b]) msk_lo_d[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
      RG_MSK_HI: for (int b = 0; b < HI_NB; b++)
                   if (wr_be[b]) msk_hi_d[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      msk_lo_q <= '1;
      msk_hi_q <= '1;
    end else if (wr_en) begin
      sta_lo_q <= sta_lo_d;
      sta_hi_q <= sta_hi_d;
      msk_lo_q <= msk_lo_d;
      msk_hi_q <= msk_hi_d;
    end
  end

  assign sta_mac  = {sta_hi_q[HI_W-1:0], sta_lo_q};
  assign msk      = {msk_hi_q, msk_lo_q};
  assign sta_ctrl = sta_hi_q[REG_W-1:HI_W];

  // R6
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && wr_be[3:2] == 2'b00) |=> $stable(sta_ctrl));
endmodule

// File: rtl/amf_masked_cmp.sv
module amf_masked_cmp
  import amf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = BYTE_W,
  localparam int NL = AW / LW
)(
  input  logic [AW-1:0] cand,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] care,
  output logic          hit
);
  logic [NL-1:0] lane_ok;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane_ok[g] =
      ((cand[g*LW +: LW] ^ ref_addr[g*LW +: LW]) & care[g*LW +: LW]) == '0;
  end

  assign hit = &lane_ok;
endmodule

// File: rtl/addr_match_filter.sv
module addr_match_filter
  import amf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic              addr_vld,
  input  logic [47:0]       frm_addr,
  output logic              match_vld,
  output logic              match_o,
  output logic [15:0]       sta_ctrl
);
  logic rst_meta_q, rst_sync_n;
  logic [ADDR_W-1:0] mac, msk;
  logic hit;
  logic vld_d, vld_q, acc_d, acc_q;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  amf_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .sta_mac  (mac),
    .msk      (msk),
    .sta_ctrl (sta_ctrl)
  );

  amf_masked_cmp #(.AW(ADDR_W), .LW(BYTE_W)) u_cmp (
    .cand     (frm_addr),
    .ref_addr (mac),
    .care     (msk),
    .hit      (hit)
  );

  always_comb begin
    vld_d = addr_vld;
    acc_d = addr_vld & hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
    end
  end

  assign match_vld = vld_q;
  assign match_o   = acc_q;

  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_vld |=> match_vld);
  // R8
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !addr_vld |=> !match_vld);
  // R8
  acc_qual_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_o |-> match_vld);
  // R2
  exact_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_vld && &msk) |=> (match_o == ($past(frm_addr) == $past(mac))));
  // R3
  open_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_vld && msk == '0) |=> match_o);
endmodule

// File: tb/test_addr_match_filter.sv
module test_addr_match_filter;
  logic clk, rst_n, wr_en, addr_vld;
  logic [1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_be;
  logic [47:0] frm_addr;
  logic match_vld, match_o;
  logic [15:0] sta_ctrl;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [47:0] m_mac, m_mask;
  logic [15:0] m_ctrl;

  addr_match_filter i_addr_match_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .addr_vld(addr_vld),
    .frm_addr(frm_addr), .match_vld(match_vld), .match_o(match_o),
    .sta_ctrl(sta_ctrl));

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic mdl(input logic [47:0] f);
    return (f & m_mask) == (m_mask & m_mac);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 0;
    for (int b = 0; b < 4; b++) if (be[b]) begin
      case (a)
        2'd0: m_mac[8*b +: 8] = d[8*b +: 8];
        2'd1: if (b < 2) m_mac[32+8*b +: 8] = d[8*b +: 8];
              else m_ctrl[8*(b-2) +: 8] = d[8*b +: 8];
        2'd2: m_mask[8*b +: 8] = d[8*b +: 8];
        default: if (b < 2) m_mask[32+8*b +: 8] = d[8*b +: 8];
      endcase
    end
  endtask

  task automatic cmp(input logic [47:0] f, input logic exp, input string req);
    @(negedge clk);
    addr_vld = 1; frm_addr = f;
    @(negedge clk);
    addr_vld = 0;
    chk({req, " vld"}, match_vld, 1);
    chk(req, match_o, exp);
  endtask

  task automatic t_reset;
    chk("R9 vld", match_vld, 0);
    chk("R9 acc", match_o, 0);
    chk("R9 ctrl", sta_ctrl, 0);
    cmp(48'h0, 1, "R9 zero addr");
    cmp(48'h1, 0, "R9 all-ones mask");
  endtask

  task automatic t_exact;
    wr(2'd0, 32'h44332211, 4'hF);
    wr(2'd1, 32'h00006655, 4'h3);
    cmp(48'h665544332211, 1, "R5 octet order");
    cmp(48'h112233445566, 0, "R5 reversed");
    cmp(48'hE65544332211, 0, "R2 bit47");
    cmp(48'h665544332210, 0, "R2 bit0");
  endtask

  task automatic t_ctrl;
    wr(2'd1, 32'hABCD6655, 4'hF);
    chk("R6 ctrl write", sta_ctrl, 16'hABCD);
    wr(2'd1, 32'h12347788, 4'h3);
    chk("R6 ctrl kept", sta_ctrl, 16'hABCD);
    cmp(48'h778844332211, mdl(48'h778844332211), "R6 addr bytes");
    chk("R6 model", m_ctrl, 16'hABCD);
  endtask

  task automatic t_open;
    wr(2'd2, 32'h0, 4'hF);
    wr(2'd3, 32'h0, 4'h3);
    cmp(48'hDEADBEEF0123, 1, "R3 any a");
    cmp(48'hFFFFFFFFFFFF, 1, "R3 any b");
  endtask

  task automatic t_false;
    wr(2'd0, 32'h1, 4'hF);
    wr(2'd1, 32'h0, 4'h3);
    wr(2'd2, 32'h2, 4'hF);
    cmp(48'hD, 1, "R4 unserved accepted");
    cmp(48'h6, 0, "R4 reject");
    cmp(48'h1, 1, "R1 own");
    cmp(48'h4, 1, "R1 served a");
    cmp(48'h9, 1, "R1 served b");
  endtask

  task automatic t_split;
    wr(2'd2, 32'hFFFFFFFF, 4'hF);
    wr(2'd3, 32'hFFFF0000, 4'hF);
    wr(2'd0, 32'hCAFE0001, 4'hF);
    cmp(48'h1234CAFE0001, 1, "R7 upper ignored");
    cmp(48'h0000CAFE0003, 0, "R7 low compared");
    @(negedge clk);
    chk("R8 idle", match_vld, 0);
    chk("R8 idle acc", match_o, 0);
  endtask

  task automatic t_same;
    wr(2'd3, 32'h0000FFFF, 4'h3);
    wr(2'd1, 32'h00000000, 4'h3);
    wr(2'd0, 32'h000000AA, 4'hF);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd0; wr_data = 32'h000000BB; wr_be = 4'hF;
    addr_vld = 1; frm_addr = 48'hAA;
    @(negedge clk);
    wr_en = 0; addr_vld = 0;
    m_mac[31:0] = 32'hBB;
    chk("R10 same-cycle old", match_o, 1);
    cmp(48'hAA, 0, "R10 old gone");
    cmp(48'hBB, 1, "R10 new used");
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_be = 0;
    addr_vld = 0; frm_addr = 0;
    m_mac = '0; m_mask = '1; m_ctrl = '0;
    repeat (3) @(negedge clk);
    chk("R9 in reset", {match_vld, match_o}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_exact;
    t_ctrl;
    t_open;
    t_false;
    t_split;
    t_same;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule